// File: doc/BRIEF.md
# Square-Wave Tone Player

This block turns a stream of pre-decoded single-voice music commands into a one-bit square wave for a speaker pin. Commands arrive as 11-bit words over a valid/ready handshake. They either change the player's settings (tempo, default note length, octave) or request a sound: a pitched note, or a silent pause. The text of a melody is parsed elsewhere.

Each pitched note gets a half-period count in system-clock cycles. The count is looked up from a built-in table of the twelve semitones and scaled by octave. Each note also gets a duration, computed from the tempo and the length. The player emits only whole waveform periods: as many as fit inside that duration. Every period has exactly the same length. When the last period of a note completes, the player is ready for the next command in that same cycle, so consecutive notes follow each other with no idle cycle.

Top module: `tone_player`

## Requirements
- R1: After reset the tempo is 120 quarter notes per minute, the default length is 4 (a quarter note) and the octave is 4. The speaker output is low and `cmd_ready_o` is high.
- R2: A command word carries an opcode in bits [10:8] and an argument in bits [7:0]. The opcodes are: 0 note, 1 length, 2 octave, 3 tempo, 4 pause. A command is taken in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high.
- R3: A note's argument holds a letter code in bits [2:0] (0=C, 1=D, 2=E, 3=F, 4=G, 5=A, 6=B; code 7 plays as B) and a sharp flag in bit 3. A B sharp plays as C one octave higher. The half-period count h is derived in three steps:
  - At octave 4, h = round(500·CLK_HZ / f), where f is the equal-tempered frequency in mHz: A = 440000 and C = 261626.
  - Each octave above 4 halves that count with a right shift, and each octave below 4 doubles it.
  - A count of zero is raised to 1.
- R4: A note's output goes high in the cycle after the note is taken. It then stays high for exactly h cycles and low for exactly h cycles in every period.
- R5: The duration is D = floor(240·CLK_HZ / (tempo·length)) cycles. A note plays floor(D / 2h) whole periods. If that count is zero, nothing is played and the player is ready again in the next cycle.
- R6: While a note plays, `cmd_ready_o` is high only in the final cycle of the last period, with the output low. A note taken in that cycle starts with no gap.
- R7: A length or tempo command with argument 0 is ignored, and the player is ready again in the next cycle. A non-zero argument replaces the setting, and the duration used by later notes follows it.
- R8: An octave command takes bits [2:0] of its argument as the new octave, effective from the next note.
- R9: A pause with argument p holds the output low for D cycles. D uses p as the length, or the current length when p is 0. The player is ready in the last cycle of the pause, which is cycle D+W+1 after acceptance, where W is the bit width of 240·CLK_HZ.
- R10: Opcodes 5 to 7 are taken and discarded. The player is ready in the next cycle, the output stays low, and no setting changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ cycles per second |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word present |
| cmd_ready_o | output | 1 | Player can take a command this cycle |
| cmd_i | input | 11 | Command word: opcode [10:8], argument [7:0] |
| spk_o | output | 1 | Square-wave speaker drive |

## Verification
The checker assumes the command source holds `cmd_valid_i` and `cmd_i` steady while a command waits for acceptance. It also assumes the source asks only for tempo and length values that fit the 8-bit argument. The bench drives command words only on falling edges and changes a word only after its acceptance edge. It sweeps every letter/sharp combination, every octave and the B-sharp wrap. It also covers a note too short for one period, pauses with explicit and default lengths, and ignored commands. Each result is compared against durations and half-periods the bench computes arithmetically from the formulas above.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned CMD_W = 11;
  localparam int unsigned ARG_W = 8;

  localparam logic [2:0] OP_NOTE  = 3'd0;
  localparam logic [2:0] OP_LEN   = 3'd1;
  localparam logic [2:0] OP_OCT   = 3'd2;
  localparam logic [2:0] OP_TEMPO = 3'd3;
  localparam logic [2:0] OP_PAUSE = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_PCALC, ST_REST} state_e;

  // equal-tempered octave-4 frequencies in mHz, semitone 0 = C
  function automatic longint unsigned semi_mhz(input int s);
    case (s)
      0:  return 64'd261626;
      1:  return 64'd277183;
      2:  return 64'd293665;
      3:  return 64'd311127;
      4:  return 64'd329628;
      5:  return 64'd349228;
      6:  return 64'd369994;
      7:  return 64'd391995;
      8:  return 64'd415305;
      9:  return 64'd440000;
      10: return 64'd466164;
      default: return 64'd493883;
    endcase
  endfunction

  function automatic longint unsigned half_oct4(input longint unsigned clk_hz, input int s);
    longint unsigned m;
    m = semi_mhz(s);
    return (clk_hz * 500 + m / 2) / m;
  endfunction

  function automatic logic [3:0] letter_semi(input logic [2:0] l);
    case (l)
      3'd0: return 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd5;
      3'd4: return 4'd7;
      3'd5: return 4'd9;
      default: return 4'd11;
    endcase
  endfunction
endpackage

// File: rtl/tone_div.sv
module tone_div #(
  parameter int unsigned NW = 24,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int unsigned CW = $clog2(NW + 1);

  logic [NW-1:0] q_q;
  logic [DW:0]   r_q, r_sh, diff;
  logic [DW-1:0] d_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, ge;

  assign r_sh = {r_q[DW-1:0], q_q[NW-1]};
  assign ge   = r_sh >= {1'b0, d_q};
  assign diff = r_sh - {1'b0, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; r_q <= '0; d_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      q_q <= num_i; r_q <= '0; d_q <= den_i; cnt_q <= CW'(NW);
      busy_q <= 1'b1; done_q <= 1'b0;
    end else if (busy_q) begin
      q_q   <= {q_q[NW-2:0], ge};
      r_q   <= ge ? diff : r_sh;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q;
endmodule

// File: rtl/tone_pitch.sv
module tone_pitch #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned HW     = 26
) (
  input  logic [2:0]    letter_i,
  input  logic          sharp_i,
  input  logic [2:0]    oct_i,
  output logic [HW-1:0] half_o
);
  logic [HW-1:0] base [12];

  for (genvar g = 0; g < 12; g++) begin : g_tab
    localparam longint unsigned BASE = tone_pkg::half_oct4(64'(CLK_HZ), g);
    assign base[g] = HW'(BASE);
  end

  logic [3:0]    semi, idx, eff;
  logic [HW-1:0] b, h;

  always_comb begin
    semi = tone_pkg::letter_semi(letter_i) + {3'd0, sharp_i};
    if (semi == 4'd12) begin
      idx = 4'd0;
      eff = {1'b0, oct_i} + 4'd1;
    end else begin
      idx = semi;
      eff = {1'b0, oct_i};
    end
    b = base[idx];
    if (eff >= 4'd4) h = b >> (eff - 4'd4);
    else             h = b << (4'd4 - eff);
    half_o = (h == '0) ? HW'(1) : h;
  end
endmodule

// File: rtl/tone_wave.sv
module tone_wave #(
  parameter int unsigned HW = 26,
  parameter int unsigned DW = 34
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [HW-1:0] half_i,
  input  logic [DW-1:0] dur_i,
  output logic          spk_o,
  output logic          busy_o,
  output logic          last_o,
  output logic [HW-1:0] half_o
);
  logic [HW-1:0] half_q, cnt_q;
  logic [DW-1:0] rem_q, two_n, two_q;
  logic          spk_q, busy_q, edge_w;

  assign two_n  = DW'(half_i) << 1;
  assign two_q  = DW'(half_q) << 1;
  assign edge_w = cnt_q == half_q - HW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HW'(1); cnt_q <= '0; rem_q <= '0;
      spk_q <= 1'b0; busy_q <= 1'b0;
    end else if (start_i) begin
      half_q <= half_i;
      cnt_q  <= '0;
      if (dur_i >= two_n) begin
        rem_q  <= dur_i - two_n;
        spk_q  <= 1'b1;
        busy_q <= 1'b1;
      end else begin
        spk_q  <= 1'b0;
        busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      if (edge_w) begin
        cnt_q <= '0;
        if (spk_q) spk_q <= 1'b0;
        else if (rem_q >= two_q) begin
          rem_q <= rem_q - two_q;
          spk_q <= 1'b1;
        end else busy_q <= 1'b0;
      end else cnt_q <= cnt_q + HW'(1);
    end
  end

  assign spk_o  = spk_q;
  assign busy_o = busy_q;
  assign last_o = busy_q && !spk_q && edge_w && (rem_q < two_q);
  assign half_o = half_q;
endmodule

// File: rtl/tone_player.sv
module tone_player
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             spk_o
);
  localparam longint unsigned NUM = 64'(CLK_HZ) * 240;
  localparam int unsigned DUR_W = $clog2(NUM + 1);
  localparam int unsigned HW    = $clog2(CLK_HZ + 1);
  localparam int unsigned DEN_W = 2 * ARG_W;
  localparam logic [DUR_W-1:0] DUR_RST = DUR_W'(NUM / 480);

  state_e            st_q;
  logic [ARG_W-1:0]  tempo_q, len_q, arg, plen;
  logic [2:0]        oct_q, op;
  logic [DUR_W-1:0]  dur_q, rest_q, quo;
  logic [DEN_W-1:0]  den;
  logic [HW-1:0]     note_half, cur_half;
  logic              accept, div_start, div_done, wave_start, wave_busy, wave_last, rest_last;

  assign op        = cmd_i[CMD_W-1:ARG_W];
  assign arg       = cmd_i[ARG_W-1:0];
  assign plen      = (arg == '0) ? len_q : arg;
  assign rest_last = (st_q == ST_REST) && (rest_q == DUR_W'(1));
  assign cmd_ready_o = ((st_q == ST_IDLE) && (!wave_busy || wave_last)) || rest_last;
  assign accept    = cmd_valid_i && cmd_ready_o;
  assign wave_start = accept && (op == OP_NOTE);

  always_comb begin
    div_start = 1'b0;
    den = DEN_W'(tempo_q) * DEN_W'(plen);
    if (accept) begin
      case (op)
        OP_LEN: begin
          div_start = arg != '0;
          den = DEN_W'(tempo_q) * DEN_W'(arg);
        end
        OP_TEMPO: begin
          div_start = arg != '0;
          den = DEN_W'(arg) * DEN_W'(len_q);
        end
        OP_PAUSE: div_start = 1'b1;
        default: ;
      endcase
    end
  end

  tone_div #(.NW(DUR_W), .DW(DEN_W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .num_i(DUR_W'(NUM)), .den_i(den),
    .done_o(div_done), .quo_o(quo)
  );

  tone_pitch #(.CLK_HZ(CLK_HZ), .HW(HW)) u_pitch (
    .letter_i(arg[2:0]), .sharp_i(arg[3]), .oct_i(oct_q), .half_o(note_half)
  );

  tone_wave #(.HW(HW), .DW(DUR_W)) u_wave (
    .clk_i, .rst_ni, .start_i(wave_start), .half_i(note_half), .dur_i(dur_q),
    .spk_o, .busy_o(wave_busy), .last_o(wave_last), .half_o(cur_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      tempo_q <= ARG_W'(120);
      len_q <= ARG_W'(4);
      oct_q <= 3'd4;
      dur_q <= DUR_RST;
      rest_q <= '0;
    end else if (accept) begin
      case (op)
        OP_LEN: if (arg != '0) begin
          len_q <= arg; st_q <= ST_CALC;
        end else st_q <= ST_IDLE;
        OP_TEMPO: if (arg != '0) begin
          tempo_q <= arg; st_q <= ST_CALC;
        end else st_q <= ST_IDLE;
        OP_OCT: begin
          oct_q <= arg[2:0]; st_q <= ST_IDLE;
        end
        OP_PAUSE: st_q <= ST_PCALC;
        default: st_q <= ST_IDLE;
      endcase
    end else begin
      case (st_q)
        ST_CALC: if (div_done) begin
          dur_q <= quo; st_q <= ST_IDLE;
        end
        ST_PCALC: if (div_done) begin
          if (quo == '0) st_q <= ST_IDLE;
          else begin
            rest_q <= quo; st_q <= ST_REST;
          end
        end
        ST_REST: begin
          rest_q <= rest_q - DUR_W'(1);
          if (rest_last) st_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tone_player_chk.sv
module tone_player_chk
  import tone_pkg::*;
#(
  parameter int unsigned HW = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [CMD_W-1:0] cmd_i,
  input logic             spk_o,
  input state_e           st,
  input logic [ARG_W-1:0] tempo,
  input logic [ARG_W-1:0] len,
  input logic [HW-1:0]    cur_half
);
  logic [HW:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_run_q <= '0;
    else if (spk_o) hi_run_q <= hi_run_q + 1'b1;
    else hi_run_q <= '0;
  end

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_ready_o |=> cmd_valid_i && $stable(cmd_i)); // R2
  AST_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spk_o) |-> hi_run_q == {1'b0, cur_half}); // R4
  AST_READY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !spk_o); // R6
  AST_CFG_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tempo != '0 && len != '0); // R7
  AST_REST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_REST |-> !spk_o); // R9
  AST_ODD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_i[CMD_W-1:ARG_W] >= 3'd5
      |=> st == ST_IDLE && $stable(tempo) && $stable(len)); // R10
endmodule

bind tone_player tone_player_chk #(.HW(HW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_i(cmd_i), .spk_o(spk_o), .st(st_q), .tempo(tempo_q), .len(len_q), .cur_half(cur_half)
);

// File: tb/sim_tone_player.sv
module sim_tone_player;
  localparam int unsigned CLK = 20000;
  localparam longint unsigned NUMB = 64'(CLK) * 240;
  localparam int W = $clog2(NUMB + 1);

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_ready, spk;
  logic [10:0] cmd = '0;
  int errors = 0, checks = 0;
  int m_tempo = 120, m_len = 4, m_oct = 4;

  always #5 clk = ~clk;

  tone_player #(.CLK_HZ(CLK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_i(cmd), .spk_o(spk)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint mhz(input int s);
    longint t[12] = '{261626, 277183, 293665, 311127, 329628, 349228,
                      369994, 391995, 415305, 440000, 466164, 493883};
    return t[s];
  endfunction

  function automatic longint exp_half(input int letter, input int sharp, input int oct);
    int sm[8] = '{0, 2, 4, 5, 7, 9, 11, 11};
    int s, e;
    longint h4, h;
    s = sm[letter] + sharp;
    e = oct;
    if (s == 12) begin s = 0; e = oct + 1; end
    h4 = (64'(CLK) * 500 + mhz(s) / 2) / mhz(s);
    h = (e >= 4) ? (h4 >> (e - 4)) : (h4 << (4 - e));
    return (h == 0) ? 1 : h;
  endfunction

  function automatic longint dur(input int tempo, input int len);
    return longint'(NUMB) / (tempo * len);
  endfunction

  task automatic run(input logic [10:0] c, output int cyc, output int rises,
                     output int hi1, output bit first_hi);
    bit prev, in_first;
    cmd_valid = 1'b1;
    cmd = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0; rises = 0; hi1 = 0; prev = 1'b0; in_first = 1'b1; first_hi = spk;
    while (1) begin
      cyc++;
      if (spk && !prev) rises++;
      if (spk && rises == 1 && in_first) hi1++;
      if (!spk && rises == 1) in_first = 1'b0;
      prev = spk;
      if (cmd_ready || cyc > 60000) break;
      @(negedge clk);
    end
  endtask

  task automatic note(input int letter, input int sharp, input string tag);
    int cyc, rises, hi1;
    bit fh;
    longint h, d, p, ec;
    h = exp_half(letter, sharp, m_oct);
    d = dur(m_tempo, m_len);
    p = d / (2 * h);
    ec = (p == 0) ? 1 : p * 2 * h;
    run({3'd0, 4'd0, 1'(sharp), 3'(letter)}, cyc, rises, hi1, fh);
    chk(rises == p, {tag, " R5 periods"}, rises, p);
    chk(cyc == ec, {tag, " R6 cycles to ready"}, cyc, ec);
    if (p > 0) begin
      chk(hi1 == h, {tag, " R3 half period"}, hi1, h);
      chk(fh == 1'b1, {tag, " R4 high after accept"}, fh, 1);
    end
  endtask

  task automatic setting(input logic [2:0] op, input int a);
    int cyc, rises, hi1;
    bit fh;
    run({op, 8'(a)}, cyc, rises, hi1, fh);
    if (op == 3'd1 && a != 0) m_len = a;
    if (op == 3'd3 && a != 0) m_tempo = a;
    if (op == 3'd2) m_oct = a % 8;
    if ((op == 3'd1 || op == 3'd3) && a == 0)
      chk(cyc == 1, "R7 zero argument ready next cycle", cyc, 1);
    if (op == 3'd2) chk(cyc == 1, "R8 octave taken at once", cyc, 1);
  endtask

  initial begin
    int cyc, rises, hi1;
    bit fh;
    int lt[12] = '{0, 0, 1, 1, 2, 3, 3, 4, 4, 5, 5, 6};
    int sh[12] = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 0, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spk == 1'b0, "R1 speaker low after reset", spk, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    note(5, 0, "R1 default A4");
    setting(3'd3, 240);
    setting(3'd1, 8);
    for (int i = 0; i < 12; i++) note(lt[i], sh[i], "R2 semitone sweep");
    for (int o = 0; o < 8; o++) begin
      setting(3'd2, o);
      note(5, 0, "R8 octave sweep");
    end
    setting(3'd2, 3);
    note(6, 1, "R3 B sharp wrap");
    note(7, 0, "R3 code 7 as B");
    setting(3'd2, 4);
    setting(3'd1, 0);
    note(0, 0, "R7 zero length kept");
    setting(3'd3, 0);
    note(2, 0, "R7 zero tempo kept");
    setting(3'd1, 2);
    note(4, 1, "R7 new length");
    setting(3'd1, 8);
    run({3'd4, 8'd16}, cyc, rises, hi1, fh);
    chk(cyc == dur(m_tempo, 16) + W + 1, "R9 pause explicit length", cyc, dur(m_tempo, 16) + W + 1);
    chk(rises == 0, "R9 pause silent", rises, 0);
    run({3'd4, 8'd0}, cyc, rises, hi1, fh);
    chk(cyc == dur(m_tempo, m_len) + W + 1, "R9 pause default length", cyc, dur(m_tempo, m_len) + W + 1);
    chk(rises == 0, "R9 default pause silent", rises, 0);
    run({3'd5, 8'd9}, cyc, rises, hi1, fh);
    chk(cyc == 1 && rises == 0, "R10 opcode 5 discarded", cyc, 1);
    run({3'd7, 8'd1}, cyc, rises, hi1, fh);
    chk(cyc == 1 && rises == 0, "R10 opcode 7 discarded", cyc, 1);
    note(5, 0, "R10 settings unchanged");
    setting(3'd3, 255);
    setting(3'd1, 64);
    setting(3'd2, 0);
    note(0, 0, "R5 too short for a period");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule